// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tags

This block buffers received characters for one serial channel. A bit-level receiver hands it each character together with four status flags (parity error, overrun, framing error, break) taken when that character arrived. The flags are stored next to the character in the same entry, so software reads them back together with the byte they belong to. A read returns one 16-bit word. A fill count shows how many entries are waiting.

A two-bit trigger code picks one of three fill levels (one entry, half the depth, seven eighths of the depth), or turns the level request off. When receive interrupts are enabled and the fill count reaches the chosen level, the block raises a data-available request. A flush control empties the buffer for as long as it is held. A receive-enable input decides whether incoming characters are stored. When the buffer is full, an incoming character is dropped and the newest stored entry is marked as overrun.

Top module: `rxfifo_err_tag`

## Requirements
- R1: After reset, `fill_count` is 0, `rx_irq` is 0 and `rd_word` is 0.
- R2: Entries are read in arrival order. A read word carries the character in bits 7:0, parity error in bit 8, overrun in bit 9, framing error in bit 10 and break in bit 11. Bits 15:12 are 0. The word appears on `rd_word` one cycle after `rd_stb` and holds until the next read.
- R3: `fill_count` is a 16-bit count of stored entries, never above DEPTH (default 512). An accepted write raises it by one and a read of a non-empty buffer lowers it by one, both one cycle after the strobe.
- R4: `trig_sel` codes are: 0 means no request, 1 means level 1, 2 means level DEPTH/2 (256), 3 means level DEPTH-DEPTH/8 (448). `rx_irq` is 1 exactly when the count is at or above the selected level. It updates in the same cycle as `fill_count`.
- R5: `rx_irq` stays 0 while `irq_en` is 0, whatever the fill level.
- R6: A write while `rx_en` is 0 is ignored and leaves `fill_count` unchanged.
- R7: While `flush` is 1 the count is forced to 0, writes are ignored and reads return 0. After `flush` returns to 0, normal storage resumes.
- R8: A write into a full buffer with no read in the same cycle drops the new character. The count stays at DEPTH, and bit 9 of the newest stored entry is set.
- R9: A read of an empty buffer returns 0 on `rd_word` and does not change `fill_count`.
- R10: A read and a write in the same cycle, including when the buffer is full, leave the count unchanged. The read returns the oldest entry and the written character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Allows incoming characters to be stored |
| irq_en | input | 1 | Allows the data-available request |
| trig_sel | input | 2 | Trigger level code |
| flush | input | 1 | Empties the buffer while high |
| wr_stb | input | 1 | Write strobe from the receiver |
| wr_char | input | 8 | Received character |
| wr_par | input | 1 | Parity error flag for this character |
| wr_ovr | input | 1 | Overrun flag for this character |
| wr_frm | input | 1 | Framing error flag for this character |
| wr_brk | input | 1 | Break flag for this character |
| rd_stb | input | 1 | Read strobe |
| rd_word | output | 16 | Read data: character and flags |
| fill_count | output | 16 | Number of stored entries |
| rx_irq | output | 1 | Data-available request |

## Verification
The hardest case to reach from the ports is the full buffer. The overrun mark is written into an entry that was stored long before, and it can only be seen after every older entry has been drained. The stimulus writes a numbered sequence of 512 characters, stepping through the 256 and 448 trigger levels on the way. At full it does one combined read and write, then one dropped write. It then drains the whole buffer and checks each word in order, so the last word must show the combined-cycle character with bit 9 set.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       ovr;
    logic       par;
    logic [7:0] ch;
  } rxf_entry_t;

  localparam int ENTRY_W = $bits(rxf_entry_t);

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_ONE  = 2'd1,
    TRIG_HALF = 2'd2,
    TRIG_HIGH = 2'd3
  } rxf_trig_e;

endpackage

// File: rtl/rxf_ram.sv
module rxf_ram #(
  parameter int DEPTH = 512,
  parameter int W     = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          flush,
  input  logic          wr_stb,
  input  logic          rd_stb,
  output logic          push,
  output logic          fix,
  output logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] wlast,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_next
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic full, empty, wr_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full     = (cnt == FULL_CNT);
    empty    = (cnt == '0);
    wr_ok    = wr_stb && rx_en && !flush;
    pop      = rd_stb && !flush && !empty;
    push     = wr_ok && (!full || pop);
    fix      = wr_ok && full && !pop;
    wlast    = (wptr == '0) ? LAST_IDX : wptr - 1'b1;
    cnt_next = flush ? '0 : cnt + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= step(wptr);
      if (pop)  rptr <= step(rptr);
    end
    if (rst) cnt <= '0;
    else     cnt <= cnt_next;
  end

endmodule

// File: rtl/rxf_trig.sv
module rxf_trig
  import rxf_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_en,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] cnt_next,
  output logic          irq
);

  localparam logic [CW-1:0] LVL_ONE  = CW'(1);
  localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LVL_HIGH = CW'(DEPTH - DEPTH / 8);

  logic [CW-1:0] lvl;
  logic          armed;

  always_comb begin
    armed = 1'b1;
    case (rxf_trig_e'(trig_sel))
      TRIG_ONE:  lvl = LVL_ONE;
      TRIG_HALF: lvl = LVL_HALF;
      TRIG_HIGH: lvl = LVL_HIGH;
      default: begin
        lvl   = LVL_ONE;
        armed = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_en && armed && (cnt_next >= lvl);
  end

endmodule

// File: rtl/rxfifo_err_tag.sv
module rxfifo_err_tag
  import rxf_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_en,
  input  logic        irq_en,
  input  logic [1:0]  trig_sel,
  input  logic        flush,
  input  logic        wr_stb,
  input  logic [7:0]  wr_char,
  input  logic        wr_par,
  input  logic        wr_ovr,
  input  logic        wr_frm,
  input  logic        wr_brk,
  input  logic        rd_stb,
  output logic [15:0] rd_word,
  output logic [15:0] fill_count,
  output logic        rx_irq
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          push, fix, pop;
  logic [AW-1:0] wptr, wlast, rptr;
  logic [CW-1:0] cnt, cnt_next;
  rxf_entry_t    new_ent, last_q, mark_ent, ram_wd, ram_rd;
  logic [AW-1:0] ram_wa;
  logic          rd_ok_q;

  rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .rx_en(rx_en), .flush(flush),
    .wr_stb(wr_stb), .rd_stb(rd_stb),
    .push(push), .fix(fix), .pop(pop),
    .wptr(wptr), .wlast(wlast), .rptr(rptr),
    .cnt(cnt), .cnt_next(cnt_next)
  );

  always_comb begin
    new_ent     = '{brk: wr_brk, frm: wr_frm, ovr: wr_ovr, par: wr_par, ch: wr_char};
    mark_ent    = last_q;
    mark_ent.ovr = 1'b1;
    ram_wa      = push ? wptr : wlast;
    ram_wd      = push ? new_ent : mark_ent;
  end

  rxf_ram #(.DEPTH(DEPTH), .W(ENTRY_W)) u_ram (
    .clk(clk), .we(push | fix), .waddr(ram_wa), .wdata(ram_wd),
    .re(pop), .raddr(rptr), .rdata(ram_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= '0;
      rd_ok_q <= 1'b0;
    end else begin
      if (push)      last_q <= new_ent;
      else if (fix)  last_q <= mark_ent;
      if (rd_stb)    rd_ok_q <= pop;
    end
  end

  assign rd_word    = rd_ok_q ? 16'(ram_rd) : 16'h0000;
  assign fill_count = 16'(cnt);

  rxf_trig #(.DEPTH(DEPTH)) u_trig (
    .clk(clk), .rst(rst), .irq_en(irq_en), .trig_sel(trig_sel),
    .cnt_next(cnt_next), .irq(rx_irq)
  );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 512
) (
  input logic        clk,
  input logic        rst,
  input logic        rx_en,
  input logic        irq_en,
  input logic [1:0]  trig_sel,
  input logic        flush,
  input logic        wr_stb,
  input logic        rd_stb,
  input logic [15:0] rd_word,
  input logic [15:0] fill_count,
  input logic        rx_irq
);

  localparam logic [15:0] FULL = 16'(DEPTH);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill_count <= FULL); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !flush |=> ((fill_count == $past(fill_count)) ||
                ({1'b0, fill_count} == {1'b0, $past(fill_count)} + 17'd1) ||
                ({1'b0, fill_count} + 17'd1 == {1'b0, $past(fill_count)}))); // R3

  AST_IRQ_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> (fill_count != 16'd0)); // R4

  AST_TRIG_OFF: assert property (@(posedge clk) disable iff (rst)
    (trig_sel == 2'd0) |=> !rx_irq); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !rx_irq); // R5

  AST_RXEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !rd_stb && !flush) |=> $stable(fill_count)); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fill_count == 16'd0)); // R7

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fill_count == FULL && wr_stb && !rd_stb && !flush) |=> (fill_count == FULL)); // R8

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (fill_count == 16'd0 && rd_stb) |=> (rd_word == 16'd0)); // R9

  AST_WORD_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_word[15:12] == 4'd0); // R2

endmodule

bind rxfifo_err_tag rxf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .irq_en(irq_en), .trig_sel(trig_sel),
  .flush(flush), .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_word(rd_word),
  .fill_count(fill_count), .rx_irq(rx_irq)
);

// File: tb/tb_rxfifo_err_tag.sv
module tb_rxfifo_err_tag;

  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_en, irq_en, flush, wr_stb, rd_stb;
  logic [1:0]  trig_sel;
  logic [7:0]  wr_char;
  logic        wr_par, wr_ovr, wr_frm, wr_brk;
  logic [15:0] rd_word, fill_count;
  logic        rx_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rxfifo_err_tag #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .irq_en(irq_en), .trig_sel(trig_sel),
    .flush(flush), .wr_stb(wr_stb), .wr_char(wr_char), .wr_par(wr_par),
    .wr_ovr(wr_ovr), .wr_frm(wr_frm), .wr_brk(wr_brk), .rd_stb(rd_stb),
    .rd_word(rd_word), .fill_count(fill_count), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock: optional write of {brk,frm,ovr,par,char} and optional read
  task automatic cyc(input bit w, input logic [11:0] wv, input bit r);
    @(negedge clk);
    wr_stb  = w;
    wr_char = wv[7:0];
    wr_par  = wv[8];
    wr_ovr  = wv[9];
    wr_frm  = wv[10];
    wr_brk  = wv[11];
    rd_stb  = r;
    @(posedge clk);
    #1;
    @(negedge clk);
    wr_stb = 0;
    rd_stb = 0;
  endtask

  task automatic idle();
    cyc(0, 12'h0, 0);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic t_reset();
    check("R1 count", fill_count, 0);
    check("R1 irq", rx_irq, 0);
    check("R1 rd_word", rd_word, 0);
  endtask

  task automatic t_order();
    trig_sel = 2'd1; irq_en = 1;
    cyc(1, 12'h141, 0);
    check("R4 level1 irq", rx_irq, 1);
    cyc(1, 12'h25A, 0);
    cyc(1, 12'h8FF, 0);
    check("R3 count after 3", fill_count, 3);
    cyc(0, 12'h0, 1);
    check("R2 first word", rd_word, 16'h0141);
    check("R3 count after read", fill_count, 2);
    cyc(0, 12'h0, 1);
    check("R2 second word", rd_word, 16'h025A);
    idle();
    check("R2 word held", rd_word, 16'h025A);
    cyc(0, 12'h0, 1);
    check("R2 break word", rd_word, 16'h08FF);
    check("R4 empty no irq", rx_irq, 0);
  endtask

  task automatic t_irq_gate();
    irq_en = 0; trig_sel = 2'd1;
    cyc(1, 12'h011, 0);
    check("R5 disabled irq", rx_irq, 0);
    @(negedge clk); irq_en = 1;
    idle();
    check("R5 enabled irq", rx_irq, 1);
    @(negedge clk); trig_sel = 2'd0;
    idle();
    check("R4 code0 no irq", rx_irq, 0);
    do_flush();
  endtask

  task automatic t_rxen();
    @(negedge clk); rx_en = 0;
    cyc(1, 12'h077, 0);
    check("R6 write ignored", fill_count, 0);
    cyc(0, 12'h0, 1);
    check("R6 nothing stored", rd_word, 0);
    @(negedge clk); rx_en = 1;
  endtask

  task automatic t_empty();
    cyc(1, 12'h033, 0);
    cyc(0, 12'h0, 1);
    check("R9 setup read", rd_word, 16'h0033);
    cyc(0, 12'h0, 1);
    check("R9 empty read zero", rd_word, 0);
    check("R9 count unchanged", fill_count, 0);
  endtask

  task automatic t_simul();
    cyc(1, 12'h4C1, 0);
    cyc(1, 12'h0C2, 1);
    check("R10 read oldest", rd_word, 16'h04C1);
    check("R10 count same", fill_count, 1);
    cyc(0, 12'h0, 1);
    check("R10 write kept", rd_word, 16'h00C2);
  endtask

  task automatic t_flush();
    for (int i = 0; i < 5; i++) cyc(1, 12'(i), 0);
    @(negedge clk); flush = 1; wr_stb = 1; wr_char = 8'h99;
    @(posedge clk); #1;
    @(negedge clk); rd_stb = 1;
    @(posedge clk); #1;
    check("R7 count during flush", fill_count, 0);
    check("R7 read during flush", rd_word, 0);
    @(negedge clk); flush = 0; wr_stb = 0; rd_stb = 0;
    idle();
    check("R7 empty after flush", fill_count, 0);
    cyc(1, 12'h1AB, 0);
    check("R7 resume count", fill_count, 1);
    cyc(0, 12'h0, 1);
    check("R7 resume data", rd_word, 16'h01AB);
  endtask

  task automatic t_full();
    @(negedge clk); trig_sel = 2'd2; irq_en = 1;
    for (int i = 0; i < 255; i++) cyc(1, 12'(i & 8'hFF), 0);
    check("R4 below half", rx_irq, 0);
    cyc(1, 12'(255), 0);
    check("R4 half level", rx_irq, 1);
    @(negedge clk); trig_sel = 2'd3;
    idle();
    check("R4 high code below", rx_irq, 0);
    for (int i = 256; i < 447; i++) cyc(1, 12'(i & 8'hFF), 0);
    check("R4 at 447", rx_irq, 0);
    cyc(1, 12'(447 & 8'hFF), 0);
    check("R4 at 448", rx_irq, 1);
    for (int i = 448; i < DEPTH; i++) cyc(1, 12'(i & 8'hFF), 0);
    check("R3 full count", fill_count, DEPTH);
    cyc(1, 12'h0A5, 1);
    check("R10 full rd+wr oldest", rd_word, 0);
    check("R10 full rd+wr count", fill_count, DEPTH);
    cyc(1, 12'h03C, 0);
    check("R8 count held", fill_count, DEPTH);
    for (int i = 1; i < DEPTH; i++) begin
      cyc(0, 12'h0, 1);
      check("R8 drain order", rd_word, i & 8'hFF);
    end
    cyc(0, 12'h0, 1);
    check("R8 newest marked", rd_word, 16'h02A5);
    check("R8 drained", fill_count, 0);
  endtask

  initial begin
    rst = 1; rx_en = 1; irq_en = 0; trig_sel = 2'd0; flush = 0;
    wr_stb = 0; rd_stb = 0; wr_char = 0;
    wr_par = 0; wr_ovr = 0; wr_frm = 0; wr_brk = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst = 0;
    t_order();
    t_irq_gate();
    t_rxen();
    t_empty();
    t_simul();
    t_flush();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule